// File: doc/BRIEF.md
# Board identification and configuration sequencer

This block runs once after reset. It works out whether the expected adapter is present and what settings it uses. It reads an identity port four times and rebuilds a 16-bit board identifier from the nibbles those reads return. It then reads configuration words from a serial EEPROM through a word-read engine that sits behind a request/done handshake. From those words it decodes the shared-memory window, checks a checksum over the whole EEPROM, and translates an encoded interrupt number.

When the sequence ends, the block raises a sticky done flag with a pass/fail result and an error code. On a pass it also presents the window base, the window size, the memory decode masks, the memory-control byte, a programmed-I/O mode flag and the interrupt line number. The steps always run in the same order, and the sequence stops at the first step that fails.

Top module: `board_cfg_seq`

## Requirements
- R1: Each identity read returns a byte whose bits 1:0 give a nibble position p (0..3) and whose bits 7:4 give the nibble. That nibble is ORed into the identifier at bits 4p+3:4p. After four reads the identifier must equal EXPECT_ID (default 16'hBABA), or the block ends with err_o=1 and makes no EEPROM read.
- R2: The page is the index of the lowest set bit of the low byte of EEPROM word 6. The window base is 0xC0000 + page×0x4000. If that byte is zero, the block ends with err_o=2.
- R3: The low byte shifted right by the page count selects the size: 0x01 gives 16384, 0x03 gives 32768, 0x07 gives 49152 and 0x0F gives 65536 bytes. Any other value ends the sequence with err_o=3.
- R4: The 16-bit wrap-around sum of EEPROM words 0..63 must equal EXPECT_ID, or the block ends with err_o=4.
- R5: pio_o is 1 when the size is 16K or less. In that case decode_o, ext_decode_o and mem_ctrl_o are 0.
- R6: Outside programmed-I/O mode, let d = ((1<<(size/16K))−1)<<page, taken to 16 bits. Then decode_o = d[7:0], ext_decode_o = ((~d>>4)&0xF0)|(d>>8), and mem_ctrl_o has bit 4 set with page[1:0] in bits 3:2.
- R7: Bits 15:13 of EEPROM word 1 hold an interrupt code. Codes 0..7 map to irq_o = 0, 9, 3, 4, 5, 10, 11, 0.
- R8: The order is fixed: four identity reads, then EEPROM word 6, then words 0..63 in ascending order, then word 1. On a pass that is 66 EEPROM reads. A failure stops all further reads.
- R9: done_o stays high until reset. On a pass, pass_o=1 and err_o=0. On a failure, pass_o=0 and every window, decode, mode and irq output is 0.
- R10: Each request stays high, with a stable EEPROM address, until its done input is seen. The identity request and the EEPROM request are never high together. Requests drop once done_o is set.
- R11: While reset is held, done_o, pass_o, err_o, id_req_o and ee_req_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; the sequence starts when it is released |
| id_req_o | output | 1 | Identity port read request |
| id_done_i | input | 1 | Identity read complete; id_data_i is valid |
| id_data_i | input | 8 | Identity byte: nibble in 7:4, position in 1:0 |
| ee_req_o | output | 1 | EEPROM word-read request |
| ee_addr_o | output | 6 | EEPROM word address |
| ee_done_i | input | 1 | EEPROM read complete; ee_data_i is valid |
| ee_data_i | input | 16 | EEPROM word |
| done_o | output | 1 | Sequence finished (sticky) |
| pass_o | output | 1 | Adapter identified and configured |
| err_o | output | 3 | 0 none, 1 identifier, 2 no page, 3 bad size, 4 checksum |
| win_base_o | output | 20 | Shared-memory window base address |
| win_size_o | output | 17 | Window size in bytes |
| pio_o | output | 1 | Programmed-I/O mode selected |
| decode_o | output | 8 | Memory decode mask, low byte |
| ext_decode_o | output | 8 | Extended decode byte |
| mem_ctrl_o | output | 8 | Memory-control byte |
| irq_o | output | 4 | Translated interrupt line |

## Verification
The bench returns identity nibbles in a rotated order, so a design that placed nibbles by read count instead of by the position field would build a wrong identifier. It covers every legal size run at different pages, including page 5 and page 6, where a page-2 mistake in the mem_ctrl field shows. It also sends a low byte that is zero, a run that is not contiguous (0x14) and a corrupt checksum word. A design that skipped a check would report a pass, and a design that kept going after a failure would show extra EEPROM reads in the counted read total. The responder also checks each EEPROM address against the expected order, so a design that summed the wrong words or read word 6 late is caught.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  typedef enum logic [2:0] {
    ERR_NONE   = 3'd0,
    ERR_ID     = 3'd1,
    ERR_NOPAGE = 3'd2,
    ERR_SIZE   = 3'd3,
    ERR_SUM    = 3'd4
  } err_e;

  typedef enum logic [2:0] {
    ST_ID, ST_IDCHK, ST_WIN, ST_SUM, ST_SUMCHK, ST_IRQ, ST_END
  } st_e;

  typedef struct packed {
    logic        ok_page;
    logic        ok_size;
    logic [2:0]  page;
    logic [19:0] base;
    logic [16:0] size;
    logic        pio;
    logic [7:0]  dec;
    logic [7:0]  ext;
    logic [7:0]  mctrl;
  } win_t;

  function automatic logic [3:0] irq_map(input logic [2:0] code);
    case (code)
      3'd1:    irq_map = 4'd9;
      3'd2:    irq_map = 4'd3;
      3'd3:    irq_map = 4'd4;
      3'd4:    irq_map = 4'd5;
      3'd5:    irq_map = 4'd10;
      3'd6:    irq_map = 4'd11;
      default: irq_map = 4'd0;
    endcase
  endfunction
endpackage

// File: rtl/bcs_id_collect.sv
module bcs_id_collect #(
  parameter int ID_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [7:0]      byte_i,
  output logic [ID_W-1:0] id_o
);
  localparam int NIBS  = ID_W / 4;
  localparam int POS_W = (NIBS > 1) ? $clog2(NIBS) : 1;

  for (genvar g = 0; g < NIBS; g++) begin : g_nib
    logic [3:0] nib_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                           nib_q <= '0;
      else if (load_i && byte_i[POS_W-1:0] == POS_W'(g))     nib_q <= nib_q | byte_i[7:4];
    end
    assign id_o[4*g +: 4] = nib_q;
  end
endmodule

// File: rtl/bcs_win_decode.sv
module bcs_win_decode
  import bcs_pkg::*;
#(
  parameter logic [19:0] WIN_ORIGIN = 20'hC0000,
  parameter logic [19:0] PAGE_SPAN  = 20'h04000,
  parameter logic [7:0]  WIDE_FLAG  = 8'h10
) (
  input  logic [7:0] cfg_i,
  output win_t       win_o
);
  logic [2:0]  page;
  logic [7:0]  run;
  logic [2:0]  units;
  logic [15:0] dec16;

  always_comb begin
    page = 3'd0;
    for (int i = 7; i >= 0; i--)
      if (cfg_i[i]) page = 3'(i);
    run = cfg_i >> page;
    win_o.ok_page = |cfg_i;
    win_o.ok_size = 1'b1;
    case (run)
      8'h01:   units = 3'd1;
      8'h03:   units = 3'd2;
      8'h07:   units = 3'd3;
      8'h0F:   units = 3'd4;
      default: begin units = 3'd0; win_o.ok_size = 1'b0; end
    endcase
    win_o.page = page;
    win_o.base = WIN_ORIGIN + 20'(page) * PAGE_SPAN;
    win_o.size = {units, 14'd0};
    win_o.pio  = (units <= 3'd1);
    dec16      = ((16'd1 << units) - 16'd1) << page;
    if (win_o.pio) begin
      win_o.dec   = '0;
      win_o.ext   = '0;
      win_o.mctrl = '0;
    end else begin
      win_o.dec   = dec16[7:0];
      win_o.ext   = (8'((~dec16) >> 4) & 8'hF0) | dec16[15:8];
      win_o.mctrl = WIDE_FLAG | {4'd0, page[1:0], 2'd0};
    end
  end
endmodule

// File: rtl/bcs_csum.sv
module bcs_csum #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         add_i,
  input  logic [W-1:0] word_i,
  output logic [W-1:0] sum_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sum_o <= '0;
    else if (add_i) sum_o <= sum_o + word_i;
  end
endmodule

// File: rtl/board_cfg_seq.sv
module board_cfg_seq
  import bcs_pkg::*;
#(
  parameter logic [15:0] EXPECT_ID = 16'hBABA,
  parameter int          EE_WORDS  = 64,
  parameter int          CFG_WORD  = 6,
  parameter int          IRQ_WORD  = 1,
  parameter int          IRQ_LSB   = 13
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  output logic        id_req_o,
  input  logic        id_done_i,
  input  logic [7:0]  id_data_i,
  output logic        ee_req_o,
  output logic [5:0]  ee_addr_o,
  input  logic        ee_done_i,
  input  logic [15:0] ee_data_i,
  output logic        done_o,
  output logic        pass_o,
  output logic [2:0]  err_o,
  output logic [19:0] win_base_o,
  output logic [16:0] win_size_o,
  output logic        pio_o,
  output logic [7:0]  decode_o,
  output logic [7:0]  ext_decode_o,
  output logic [7:0]  mem_ctrl_o,
  output logic [3:0]  irq_o
);
  localparam int ID_W = 16;
  localparam int NIBS = ID_W / 4;
  localparam int AW   = $clog2(EE_WORDS);

  st_e         st_q;
  logic        req_q;
  logic [AW-1:0] cnt_q;
  logic        pass_q, done_q;
  err_e        err_q;
  win_t        win_w, win_q;
  logic [3:0]  irq_q;
  logic [15:0] id_w, sum_w;
  logic        id_ack, ee_ack;

  assign id_req_o = req_q && (st_q == ST_ID);
  assign ee_req_o = req_q && (st_q == ST_WIN || st_q == ST_SUM || st_q == ST_IRQ);
  assign id_ack   = id_req_o && id_done_i;
  assign ee_ack   = ee_req_o && ee_done_i;

  always_comb begin
    case (st_q)
      ST_SUM:  ee_addr_o = 6'(cnt_q);
      ST_IRQ:  ee_addr_o = 6'(IRQ_WORD);
      default: ee_addr_o = 6'(CFG_WORD);
    endcase
  end

  bcs_id_collect #(.ID_W(ID_W)) u_id (
    .clk_i, .rst_ni, .load_i(id_ack), .byte_i(id_data_i), .id_o(id_w)
  );

  bcs_win_decode u_win (.cfg_i(ee_data_i[7:0]), .win_o(win_w));

  bcs_csum #(.W(16)) u_sum (
    .clk_i, .rst_ni, .add_i(ee_ack && st_q == ST_SUM), .word_i(ee_data_i), .sum_o(sum_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_ID; req_q <= 1'b0; cnt_q <= '0;
      pass_q <= 1'b0; done_q <= 1'b0; err_q <= ERR_NONE;
      win_q <= '0; irq_q <= '0;
    end else begin
      case (st_q)
        ST_ID: begin
          if (!req_q) req_q <= 1'b1;
          else if (id_done_i) begin
            req_q <= 1'b0;
            if (cnt_q == AW'(NIBS - 1)) begin cnt_q <= '0; st_q <= ST_IDCHK; end
            else cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_IDCHK: begin
          if (id_w == EXPECT_ID) st_q <= ST_WIN;
          else begin err_q <= ERR_ID; done_q <= 1'b1; st_q <= ST_END; end
        end
        ST_WIN: begin
          if (!req_q) req_q <= 1'b1;
          else if (ee_done_i) begin
            req_q <= 1'b0;
            win_q <= win_w;
            if (!win_w.ok_page)      begin err_q <= ERR_NOPAGE; done_q <= 1'b1; st_q <= ST_END; end
            else if (!win_w.ok_size) begin err_q <= ERR_SIZE;   done_q <= 1'b1; st_q <= ST_END; end
            else st_q <= ST_SUM;
          end
        end
        ST_SUM: begin
          if (!req_q) req_q <= 1'b1;
          else if (ee_done_i) begin
            req_q <= 1'b0;
            if (cnt_q == AW'(EE_WORDS - 1)) begin cnt_q <= '0; st_q <= ST_SUMCHK; end
            else cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_SUMCHK: begin
          if (sum_w == EXPECT_ID) st_q <= ST_IRQ;
          else begin err_q <= ERR_SUM; done_q <= 1'b1; st_q <= ST_END; end
        end
        ST_IRQ: begin
          if (!req_q) req_q <= 1'b1;
          else if (ee_done_i) begin
            req_q  <= 1'b0;
            irq_q  <= irq_map(ee_data_i[IRQ_LSB +: 3]);
            pass_q <= 1'b1;
            done_q <= 1'b1;
            st_q   <= ST_END;
          end
        end
        default: req_q <= 1'b0;
      endcase
    end
  end

  assign done_o       = done_q;
  assign pass_o       = pass_q;
  assign err_o        = err_q;
  assign win_base_o   = pass_q ? win_q.base  : '0;
  assign win_size_o   = pass_q ? win_q.size  : '0;
  assign pio_o        = pass_q ? win_q.pio   : 1'b0;
  assign decode_o     = pass_q ? win_q.dec   : '0;
  assign ext_decode_o = pass_q ? win_q.ext   : '0;
  assign mem_ctrl_o   = pass_q ? win_q.mctrl : '0;
  assign irq_o        = pass_q ? irq_q       : '0;

  assert_id_req_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_req_o && !id_done_i) |=> id_req_o);
  assert_ee_req_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ee_req_o && !ee_done_i) |=> (ee_req_o && $stable(ee_addr_o)));
  assert_one_port_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(id_req_o && ee_req_o));
  assert_quiet_after_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!id_req_o && !ee_req_o));
  assert_done_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (done_o && $stable(err_o) && $stable(pass_o)));
  assert_result_code_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (pass_o == (err_o == 3'd0)));
  assert_pio_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pio_o |-> (decode_o == 8'd0 && ext_decode_o == 8'd0 && mem_ctrl_o == 8'd0));
  assert_fail_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !pass_o) |-> (win_size_o == 17'd0 && irq_o == 4'd0));
endmodule

// File: tb/board_cfg_seq_bench.sv
`timescale 1ns/1ps
module board_cfg_seq_bench;
  localparam logic [15:0] EXP_ID = 16'hBABA;

  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic        id_req, id_done, ee_req, ee_done, done, pass, pio;
  logic [7:0]  id_data, dec, ext, mctrl;
  logic [5:0]  ee_addr;
  logic [15:0] ee_data;
  logic [2:0]  err;
  logic [19:0] base;
  logic [16:0] size;
  logic [3:0]  irq;

  board_cfg_seq u_board_cfg_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .id_req_o(id_req), .id_done_i(id_done), .id_data_i(id_data),
    .ee_req_o(ee_req), .ee_addr_o(ee_addr), .ee_done_i(ee_done), .ee_data_i(ee_data),
    .done_o(done), .pass_o(pass), .err_o(err), .win_base_o(base), .win_size_o(size),
    .pio_o(pio), .decode_o(dec), .ext_decode_o(ext), .mem_ctrl_o(mctrl), .irq_o(irq)
  );

  typedef struct {
    string tag; int err; int pass; int base; int size; int pio;
    int dec; int ext; int mctrl; int irq; int reads;
  } exp_t;
  exp_t q[$];

  logic [15:0] ee_mem [64];
  logic [7:0]  id_bytes [4];
  int id_idx, ee_cnt, addr_bad;
  int n_cmp = 0, n_bad = 0;
  bit seen;

  // responders: one-cycle latency, done held one cycle
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_done <= 0; id_data <= 0; id_idx <= 0;
      ee_done <= 0; ee_data <= 0; ee_cnt <= 0; addr_bad <= 0;
    end else begin
      if (id_done) id_done <= 0;
      else if (id_req) begin id_done <= 1; id_data <= id_bytes[id_idx[1:0]]; id_idx <= id_idx + 1; end
      if (ee_done) ee_done <= 0;
      else if (ee_req) begin
        automatic int ea = (ee_cnt == 0) ? 6 : (ee_cnt <= 64) ? ee_cnt - 1 : 1;
        if (int'(ee_addr) != ea) addr_bad <= addr_bad + 1;
        ee_done <= 1; ee_data <= ee_mem[ee_addr]; ee_cnt <= ee_cnt + 1;
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected item when done rises
  initial forever begin
    @(negedge clk);
    if (!rst_n) seen = 0;
    else if (done && !seen && q.size() > 0) begin
      automatic exp_t e = q.pop_front();
      seen = 1;
      chk({e.tag, " R9 err"},  int'(err),  e.err);
      chk({e.tag, " R9 pass"}, int'(pass), e.pass);
      chk({e.tag, " R2 base"}, int'(base), e.base);
      chk({e.tag, " R3 size"}, int'(size), e.size);
      chk({e.tag, " R5 pio"},  int'(pio),  e.pio);
      chk({e.tag, " R6 dec"},  int'(dec),  e.dec);
      chk({e.tag, " R6 ext"},  int'(ext),  e.ext);
      chk({e.tag, " R6 mctrl"}, int'(mctrl), e.mctrl);
      chk({e.tag, " R7 irq"},  int'(irq),  e.irq);
      chk({e.tag, " R8 reads"}, ee_cnt, e.reads);
      chk({e.tag, " R8 addr order"}, addr_bad, 0);
    end
  end

  task automatic build(input logic [7:0] cfg, input logic [2:0] icode, input bit bad_sum);
    logic [15:0] s = 0;
    for (int i = 0; i < 64; i++) ee_mem[i] = 16'(i * 16'h0107 + 16'h2345);
    ee_mem[6] = {8'hA5, cfg};
    ee_mem[1] = {icode, 13'h0ABC};
    for (int i = 0; i < 63; i++) s = s + ee_mem[i];
    ee_mem[63] = EXP_ID - s + (bad_sum ? 16'd1 : 16'd0);
  endtask

  task automatic set_id(input bit rotated, input bit bad);
    // byte = {nibble, 2'b10 filler, position}
    logic [3:0] n [4];
    n[0] = 4'hA; n[1] = 4'hB; n[2] = bad ? 4'h9 : 4'hA; n[3] = 4'hB;
    if (rotated) begin
      id_bytes[0] = {n[3], 2'b10, 2'd3}; id_bytes[1] = {n[1], 2'b10, 2'd1};
      id_bytes[2] = {n[0], 2'b10, 2'd0}; id_bytes[3] = {n[2], 2'b10, 2'd2};
    end else
      for (int i = 0; i < 4; i++) id_bytes[i] = {n[i], 2'b10, 2'(i)};
  endtask

  task automatic run(input exp_t e);
    int k = 0;
    q.push_back(e);
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    while (q.size() > 0 && k < 2000) begin @(negedge clk); k++; end
    repeat (20) @(negedge clk);
    chk({e.tag, " R9 done held"}, int'(done), 1);
    chk({e.tag, " R8 no reads after done"}, ee_cnt, e.reads);
  endtask

  function automatic exp_t mk(string t, int er, int b, int sz, int p, int d, int x, int m, int ir, int rd);
    exp_t e;
    e.tag = t; e.err = er; e.pass = (er == 0); e.base = b; e.size = sz; e.pio = p;
    e.dec = d; e.ext = x; e.mctrl = m; e.irq = ir; e.reads = rd;
    return e;
  endfunction

  initial begin
    set_id(0, 0); build(8'h3C, 3'd1, 0);
    repeat (2) @(negedge clk);
    // R11 reset state
    chk("R11 done", int'(done), 0); chk("R11 pass", int'(pass), 0);
    chk("R11 err", int'(err), 0);
    chk("R11 reqs", int'(id_req | ee_req), 0);

    run(mk("R1 R6 64K@page2", 0, 'hC8000, 65536, 0, 'h3C, 'hF0, 'h18, 9, 66));
    set_id(1, 0); build(8'h80, 3'd5, 0);
    run(mk("R1 rotated R5 16K@page7", 0, 'hDC000, 16384, 1, 0, 0, 0, 10, 66));
    set_id(0, 0); build(8'h70, 3'd7, 0);
    run(mk("R3 48K@page4 R7 code7", 0, 'hD0000, 49152, 0, 'h70, 'hF0, 'h10, 0, 66));
    build(8'hC0, 3'd2, 0);
    run(mk("R3 32K@page6", 0, 'hD8000, 32768, 0, 'hC0, 'hF0, 'h18, 3, 66));
    build(8'hE0, 3'd6, 0);
    run(mk("R6 48K@page5", 0, 'hD4000, 49152, 0, 'hE0, 'hF0, 'h14, 11, 66));
    build(8'h01, 3'd3, 0);
    run(mk("R5 16K@page0", 0, 'hC0000, 16384, 1, 0, 0, 0, 4, 66));
    set_id(1, 1); build(8'h3C, 3'd1, 0);
    run(mk("R1 bad id", 1, 0, 0, 0, 0, 0, 0, 0, 0));
    set_id(0, 0); build(8'h00, 3'd1, 0);
    run(mk("R2 no page", 2, 0, 0, 0, 0, 0, 0, 0, 1));
    build(8'h14, 3'd1, 0);
    run(mk("R3 gap run", 3, 0, 0, 0, 0, 0, 0, 0, 1));
    build(8'h3C, 3'd1, 1);
    run(mk("R4 bad sum", 4, 0, 0, 0, 0, 0, 0, 0, 65));

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog R8 actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule